// File: doc/BRIEF.md
# Cross-CPU Debug Halt Controller

This block couples the debug halt state of two processors, a main CPU and a radio CPU, so that a halt on one core can be passed on to the other. Each direction of propagation has its own enable. A single sensitivity bit chooses how a halt is passed on. In level mode the request follows the source core's halted signal. In pulse mode a rising edge of that signal gives a one-cycle request.

The block holds one 32-bit debug control word behind a simple write strobe and a combinational read port. Reading the word also returns the halted state of both cores, as seen one cycle earlier. It further produces a stall-out-of-reset signal for the main CPU. At each wake-up that signal is latched from two control bits and the wake source, and it is held until software clears the bit that caused it.

Top module: `xhalt_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000101, and the stall and both halt request outputs are low.
- R2: Bit 2 enables main-to-radio propagation and bit 3 enables radio-to-main propagation. While a direction's bit is 0, its halt request output stays low.
- R3: With bit 8 at 0 (level mode) and the direction enabled, the halt request to the target is high in every cycle in which the source halted input is high.
- R4: With bit 8 at 1 (pulse mode) and the direction enabled, the request is high only in a cycle where the source halted input is high and was low at the previous clock edge. A held halt therefore gives exactly one cycle of request.
- R5: Read bit 4 shows the main CPU's halted input and read bit 5 shows the radio CPU's halted input, each as sampled at the last clock edge. Writes to bits 4 and 5 have no effect.
- R6: Bits 0, 1, 2, 3, 6, 7 and 8 are read/write storage. Bits 9 to 31 always read 0, and writes to them have no effect.
- R7: A wake-up while bit 6 is 1 sets the stall output at that clock edge, whatever the wake source. The stall never rises without a wake-up.
- R8: A wake-up while bit 7 is 1 and bit 6 is 0 stalls only if the wake-from-debug input is high in that cycle.
- R9: Once set, the stall stays high until the control bit that caused it is cleared. It drops at the edge that performs that write.
- R10: When a write and a wake-up fall in the same cycle, the stall decision uses the newly written control value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Write strobe for the control word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Control word with halted status |
| mainHalted | input | 1 | Main CPU reports halted |
| radioHalted | input | 1 | Radio CPU reports halted |
| haltToMain | output | 1 | Halt request to the main CPU |
| haltToRadio | output | 1 | Halt request to the radio CPU |
| wakeUp | input | 1 | One-cycle wake-up event |
| wakeFromDebug | input | 1 | Wake-up was caused by debug activity |
| mainStall | output | 1 | Holds the main CPU stalled out of reset |

## Verification
Two functions can act in the same cycle: a control-word write and a wake-up. The write may set or clear bit 6 or bit 7 in the very cycle in which the wake-up is evaluated. Directed steps drive both in one cycle, once setting bit 6 and once clearing it. The stall seen after that edge must match the new control value, not the old one. Random stimulus also lets the two collide often. Each collision is judged against a bench model that applies the write before it evaluates the wake-up.

// File: rtl/xhalt_pkg.sv
package xhalt_pkg;
  localparam int NUM_CPU    = 2;
  localparam int MAIN_IDX   = 0;
  localparam int RADIO_IDX  = 1;
  localparam int EN_LSB     = 2;
  localparam int STAT_LSB   = 4;
  localparam int STALL_BIT  = 6;
  localparam int DBGST_BIT  = 7;
  localparam int PULSE_BIT  = 8;
  localparam int USED_BITS  = 9;
  localparam logic [USED_BITS-1:0] WR_MASK   = 9'h1CF;
  localparam logic [USED_BITS-1:0] RST_VALUE = 9'h101;

  typedef struct packed {
    logic wrCtl;
    logic wake;
  } strobe_t;
endpackage

// File: rtl/xhalt_ctl.sv
module xhalt_ctl
  import xhalt_pkg::*;
(
  input  logic               regWe,
  input  logic               wakeUp,
  input  logic [NUM_CPU-1:0] halted,
  input  logic [NUM_CPU-1:0] haltedQ,
  input  logic [NUM_CPU-1:0] dirEn,
  input  logic               pulseMode,
  output strobe_t            strobes,
  output logic [NUM_CPU-1:0] haltReq
);
  always_comb begin
    strobes       = '0;
    strobes.wrCtl = regWe;
    strobes.wake  = wakeUp;
  end

  for (genvar s = 0; s < NUM_CPU; s++) begin : g_dir
    logic event_s;
    assign event_s = pulseMode ? (halted[s] & ~haltedQ[s]) : halted[s];
    assign haltReq[NUM_CPU-1-s] = dirEn[s] & event_s;
  end
endmodule

// File: rtl/xhalt_dp.sv
module xhalt_dp
  import xhalt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_CPU-1:0] halted,
  input  logic               wakeFromDebug,
  output logic [NUM_CPU-1:0] haltedQ,
  output logic [NUM_CPU-1:0] dirEn,
  output logic               pulseMode,
  output logic               stall,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_W = DATA_W - USED_BITS;

  logic [USED_BITS-1:0] ctlQ, ctlNext;
  logic                 dbgCauseQ;
  logic                 stallNext;

  assign ctlNext = strobes.wrCtl ? (wdata[USED_BITS-1:0] & WR_MASK) : ctlQ;

  always_comb begin
    if (strobes.wake)
      stallNext = ctlNext[STALL_BIT] | (ctlNext[DBGST_BIT] & wakeFromDebug);
    else
      stallNext = stall & (ctlNext[STALL_BIT] | (ctlNext[DBGST_BIT] & dbgCauseQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ      <= RST_VALUE;
      haltedQ   <= '0;
      stall     <= 1'b0;
      dbgCauseQ <= 1'b0;
    end else begin
      ctlQ    <= ctlNext;
      haltedQ <= halted;
      stall   <= stallNext;
      if (strobes.wake) dbgCauseQ <= wakeFromDebug;
    end
  end

  assign dirEn     = ctlQ[EN_LSB +: NUM_CPU];
  assign pulseMode = ctlQ[PULSE_BIT];

  always_comb begin
    rdata = {{PAD_W{1'b0}}, ctlQ};
    rdata[STAT_LSB +: NUM_CPU] = haltedQ;
  end
endmodule

// File: rtl/xhalt_ctrl.sv
module xhalt_ctrl
  import xhalt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              mainHalted,
  input  logic              radioHalted,
  output logic              haltToMain,
  output logic              haltToRadio,
  input  logic              wakeUp,
  input  logic              wakeFromDebug,
  output logic              mainStall
);
  strobe_t            strobes;
  logic [NUM_CPU-1:0] halted, haltedQ, dirEn, haltReq;
  logic               pulseMode;

  assign halted[MAIN_IDX]  = mainHalted;
  assign halted[RADIO_IDX] = radioHalted;

  xhalt_ctl u_ctl (
    .regWe(regWe), .wakeUp(wakeUp), .halted(halted), .haltedQ(haltedQ),
    .dirEn(dirEn), .pulseMode(pulseMode), .strobes(strobes), .haltReq(haltReq)
  );

  xhalt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(regWdata),
    .halted(halted), .wakeFromDebug(wakeFromDebug), .haltedQ(haltedQ),
    .dirEn(dirEn), .pulseMode(pulseMode), .stall(mainStall), .rdata(regRdata)
  );

  assign haltToMain  = haltReq[MAIN_IDX];
  assign haltToRadio = haltReq[RADIO_IDX];
endmodule

// File: rtl/xhalt_chk.sv
module xhalt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [DATA_W-1:0] regRdata,
  input logic              mainHalted,
  input logic              haltToMain,
  input logic              haltToRadio,
  input logic              wakeUp,
  input logic              mainStall
);
  AST_DIR_OFF_RADIO: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[2] |-> !haltToRadio); // R2
  AST_DIR_OFF_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[3] |-> !haltToMain); // R2
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdata[8] && regRdata[2] && mainHalted) |-> haltToRadio); // R3
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (haltToRadio && regRdata[8] && !regWe) |=> !haltToRadio); // R4
  AST_STATUS_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> regRdata[4] == $past(mainHalted)); // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:9] == '0); // R6
  AST_NO_SPURIOUS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (!mainStall && !wakeUp) |=> !mainStall); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mainStall && !wakeUp && !regWe) |=> mainStall); // R9
endmodule

bind xhalt_ctrl xhalt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRdata(regRdata),
  .mainHalted(mainHalted), .haltToMain(haltToMain), .haltToRadio(haltToRadio),
  .wakeUp(wakeUp), .mainStall(mainStall)
);

// File: tb/xhalt_ctrl_tb.sv
module xhalt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mainHalted = 1'b0, radioHalted = 1'b0;
  logic        haltToMain, haltToRadio;
  logic        wakeUp = 1'b0, wakeFromDebug = 1'b0;
  logic        mainStall;

  int tests = 0;
  int fails = 0;

  logic [8:0] mCtl;
  logic [1:0] mHq;
  logic       mStall, mDbg;

  always #5 clk = ~clk;

  xhalt_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .mainHalted(mainHalted), .radioHalted(radioHalted), .haltToMain(haltToMain),
    .haltToRadio(haltToRadio), .wakeUp(wakeUp), .wakeFromDebug(wakeFromDebug),
    .mainStall(mainStall)
  );

  function automatic logic [31:0] expRead(logic [8:0] c, logic [1:0] hq);
    logic [31:0] r;
    r = {23'd0, c & 9'h1CF};
    r[5:4] = hq;
    return r;
  endfunction

  function automatic logic expReq(logic [8:0] c, int src, logic h, logic hq);
    if (!c[2+src]) return 1'b0;
    return c[8] ? (h & ~hq) : h;
  endfunction

  function automatic logic stallCond(logic [8:0] c, logic d);
    return c[6] | (c[7] & d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqTag(logic [8:0] c, int src);
    if (!c[2+src]) return "R2";
    return c[8] ? "R4" : "R3";
  endfunction

  task automatic step(logic we, logic [31:0] wd, logic mh, logic rh,
                      logic wk, logic wdb, string stallTag);
    logic [8:0] nc;
    regWe = we; regWdata = wd; mainHalted = mh; radioHalted = rh;
    wakeUp = wk; wakeFromDebug = wdb;
    #1;
    chk(reqTag(mCtl, 0), haltToRadio, expReq(mCtl, 0, mh, mHq[0]));
    chk(reqTag(mCtl, 1), haltToMain,  expReq(mCtl, 1, rh, mHq[1]));
    @(posedge clk);
    nc = we ? (wd[8:0] & 9'h1CF) : mCtl;
    if (wk) begin
      mStall = stallCond(nc, wdb);
      mDbg = wdb;
    end else begin
      mStall = mStall & stallCond(nc, mDbg);
    end
    mCtl = nc;
    mHq = {rh, mh};
    @(negedge clk);
    chk("R6", regRdata[31:9], 32'd0);
    chk("R6", {23'd0, regRdata[8:0] & 9'h1CF}, {23'd0, mCtl});
    chk("R5", regRdata[5:4], mHq);
    chk(stallTag, mainStall, mStall);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mCtl = 9'h101; mHq = 2'b00; mStall = 1'b0; mDbg = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", regRdata, 32'h0000_0101);
    chk("R1", mainStall, 1'b0);
    chk("R1", {haltToMain, haltToRadio}, 2'b00);

    // R3: level mode, both directions enabled, held halt
    step(1, 32'h0000_000C, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    // R4: pulse mode, held halt gives one cycle only
    step(1, 32'h0000_010C, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, "R9");
    // R5 and R6: writes to status and high bits ignored
    step(1, 32'hFFFF_FE30, 0, 0, 0, 0, "R9");
    // R7: bit 6 stalls on any wake source
    step(1, 32'h0000_0040, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(1, 32'h0000_0000, 0, 0, 0, 0, "R9");
    // R8: bit 7 stalls only on debug wake
    step(1, 32'h0000_0080, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 1, 1, "R8");
    step(1, 32'h0000_0000, 0, 0, 0, 0, "R9");
    // R10: write and wake in the same cycle
    step(1, 32'h0000_0040, 0, 0, 1, 0, "R10");
    step(1, 32'h0000_0000, 0, 0, 1, 0, "R10");

    for (int i = 0; i < 2000; i++) begin
      logic we, wk;
      logic [31:0] wd;
      we = ($urandom % 4) == 0;
      wk = ($urandom % 6) == 0;
      wd = $urandom;
      step(we, wd, $urandom % 2, $urandom % 2, wk, $urandom % 2,
           (we && wk) ? "R10" : (wk ? "R8" : "R9"));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule